// File: doc/BRIEF.md
# Five-Stage In-Order Core with a Single Memory Port

This block is a small in-order integer core built as a five-stage pipe: fetch, decode with register read, execute or address formation, memory access, and write-back. Instruction fetch and data loads and stores go through one single-ported memory. A load or store that reaches the memory stage takes the port for that cycle. Fetch then waits, and an empty slot travels down the pipe behind it.

Data dependencies are resolved by holding the dependent instruction in decode. The register file is written early in the cycle, so a value being written back can be read in the same cycle. A debug select reads out any register combinationally. A counter reports how many instructions have completed. It lets a bench measure the cost of stalls: once the pipe is full, one instruction completes per cycle, and every stall adds exactly one cycle.

Top module: `pipe5_core`

## Requirements
- R1: Reset (synchronous, active high) sets the PC to 0, empties every stage and clears the registers and the completion count. While no data access is pending, the PC is driven on `mem_addr`, the returned word is captured as the next instruction, and the PC advances by 4.
- R2: Instructions are 32 bits with opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and immediate [15:0], which is sign-extended. Opcode 1 computes rd = rs + rt, 2 computes rd = rs - rt, 3 computes rd = rs & rt, 4 computes rd = rs | rt, and 0 is a no-op.
- R3: Opcode 8 (load) writes rt with the memory word at rs + imm. Opcode 9 (store) writes rt to memory at rs + imm, with `mem_we` high for one cycle.
- R4: While a load or store is in the memory stage, `mem_addr` carries its data address and fetch is held for that cycle. An empty slot then enters decode in place of a new instruction.
- R5: An instruction in decode whose source register (rs for every opcode other than no-op, and also rt for opcodes 1 to 4 and 9) equals the nonzero destination of a valid instruction in execute or memory is held in decode, and an empty slot enters execute.
- R6: A register being written back in a cycle is read with its new value by decode in that same cycle, so no stall is taken against the write-back stage.
- R7: Register 0 always reads 0. Writes to it are discarded, and it never causes an interlock.
- R8: `retired` increments once for each non-empty instruction that leaves write-back, including no-ops. A program of N instructions completes N + 4 + S cycles after reset, where S is the number of cycles lost to stalls.
- R9: Empty slots never write the register file or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address on the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 32 | Word read combinationally from `mem_addr` |
| dbg_sel | input | 5 | Register index for debug read |
| dbg_reg | output | 32 | Contents of the selected register |
| retired | output | 32 | Count of completed instructions |

## Verification
The hardest case to reach is a load followed directly by a consumer of its result. Here the interlock against execute, the interlock against memory and the port conflict all fall into consecutive cycles, and the port conflict overlaps the second interlock cycle, so it costs nothing extra. A dedicated program produces exactly this load-use pair, and the bench checks that the total is two lost cycles, not three. Separate programs keep memory-port stalls apart from dependency stalls. This makes each completion time predictable from the instruction count alone.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  parameter int PCSTEP = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [XLEN-1:0]         mem_addr,
  output logic [XLEN-1:0]         mem_wdata,
  output logic                    mem_we,
  input  logic [XLEN-1:0]         mem_rdata,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [XLEN-1:0]         dbg_reg,
  output logic [31:0]             retired
);
  localparam int RW = $clog2(NREG);
  localparam logic [5:0] OP_NOP = 6'd0, OP_ADD = 6'd1, OP_SUB = 6'd2,
                         OP_AND = 6'd3, OP_OR = 6'd4, OP_LW = 6'd8, OP_SW = 6'd9;

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] rf [NREG];

  logic            d_v;
  logic [31:0]     d_ir;
  logic            x_v, m_v, w_v;
  logic [5:0]      x_op, m_op;
  logic [RW-1:0]   x_dst, m_dst, w_dst;
  logic [XLEN-1:0] x_a, x_b, x_imm, m_res, m_sd, w_val;

  wire [5:0]    d_op = d_ir[31:26];
  wire [RW-1:0] d_rs = d_ir[21+:RW];
  wire [RW-1:0] d_rt = d_ir[16+:RW];
  wire [RW-1:0] d_rd = d_ir[11+:RW];
  wire d_alu    = d_op inside {OP_ADD, OP_SUB, OP_AND, OP_OR};
  wire d_use_rs = d_alu || d_op == OP_LW || d_op == OP_SW;
  wire d_use_rt = d_alu || d_op == OP_SW;
  wire [RW-1:0] d_dst = d_op == OP_LW ? d_rt : (d_alu ? d_rd : '0);

  function automatic logic busy(input logic [RW-1:0] r);
    return r != '0 && ((x_v && x_dst == r) || (m_v && m_dst == r));
  endfunction

  function automatic logic [XLEN-1:0] rd_reg(input logic [RW-1:0] r);
    if (r == '0) return '0;
    if (w_v && w_dst == r) return w_val;
    return rf[r];
  endfunction

  wire hazard = d_v && ((d_use_rs && busy(d_rs)) || (d_use_rt && busy(d_rt)));
  wire mem_conflict = m_v && (m_op == OP_LW || m_op == OP_SW);

  logic [XLEN-1:0] alu;
  always_comb begin
    case (x_op)
      OP_ADD:  alu = x_a + x_b;
      OP_SUB:  alu = x_a - x_b;
      OP_AND:  alu = x_a & x_b;
      OP_OR:   alu = x_a | x_b;
      default: alu = x_a + x_imm;
    endcase
  end

  assign mem_addr  = mem_conflict ? m_res : pc;
  assign mem_we    = m_v && m_op == OP_SW;
  assign mem_wdata = m_sd;
  assign dbg_reg   = rf[dbg_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      d_v <= 1'b0; d_ir <= '0;
      x_v <= 1'b0; x_op <= OP_NOP; x_dst <= '0; x_a <= '0; x_b <= '0; x_imm <= '0;
      m_v <= 1'b0; m_op <= OP_NOP; m_dst <= '0; m_res <= '0; m_sd <= '0;
      w_v <= 1'b0; w_dst <= '0; w_val <= '0;
      retired <= '0;
    end else begin
      if (hazard) begin
        x_v <= 1'b0; x_op <= OP_NOP; x_dst <= '0;
      end else begin
        x_v   <= d_v;
        x_op  <= d_op;
        x_dst <= d_v ? d_dst : '0;
        x_a   <= rd_reg(d_rs);
        x_b   <= rd_reg(d_rt);
        x_imm <= {{(XLEN-16){d_ir[15]}}, d_ir[15:0]};
        if (mem_conflict) begin
          d_v <= 1'b0; d_ir <= '0;
        end else begin
          d_v <= 1'b1; d_ir <= mem_rdata[31:0];
          pc  <= pc + XLEN'(PCSTEP);
        end
      end
      m_v <= x_v; m_op <= x_op; m_dst <= x_dst; m_res <= alu; m_sd <= x_b;
      w_v <= m_v; w_dst <= m_dst;
      w_val <= m_op == OP_LW ? mem_rdata : m_res;
      if (w_v) retired <= retired + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (w_v && w_dst != '0) begin
      rf[w_dst] <= w_val;
    end
  end
endmodule

module pipe5_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        conflict,
  input logic        hazard,
  input logic        x_v,
  input logic [31:0] rf0,
  input logic [31:0] retired
);
  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!conflict && !hazard) |=> pc == $past(pc) + 32'd4);
  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    conflict |=> pc == $past(pc));
  p_interlock_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    hazard |=> !x_v);
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    rf0 == 32'd0);
  p_retire_step_r8: assert property (@(posedge clk) disable iff (rst)
    retired == $past(retired) || retired == $past(retired) + 32'd1);
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .conflict(mem_conflict), .hazard(hazard),
  .x_v(x_v), .rf0(rf[0]), .retired(retired)
);

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_reg, retired;
  logic        mem_we;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] mem [128];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pipe5_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_sel(dbg_sel),
    .dbg_reg(dbg_reg), .retired(retired)
  );

  assign mem_rdata = mem[mem_addr[8:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;

  function automatic logic [31:0] rr(input logic [5:0] op, input int rd, input int rs, input int rt);
    return {op, 5'(rs), 5'(rt), 5'(rd), 11'd0};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = 32'd0;
    mem[64] = 32'd5;
    mem[65] = 32'd7;
  endtask

  task automatic reg_is(input string req, input int r, input logic [31:0] exp);
    @(negedge clk);
    dbg_sel = 5'(r);
    #1;
    chk(req, $sformatf("r%0d", r), dbg_reg, exp);
  endtask

  task automatic run(input string req, input int n, input int exp_cycles);
    int cyc = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (retired == 32'(n)) break;
    end
    chk(req, "completion cycle", 32'(cyc), 32'(exp_cycles));
    repeat (8) @(posedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset retired", retired, 32'd0);
    chk("R1", "reset fetch address", mem_addr, 32'd0);
    chk("R9", "reset store strobe", {31'd0, mem_we}, 32'd0);
  endtask

  task automatic t_mem_program();
    clear_mem();
    mem[0]  = ri(6'd8, 1, 0, 16'h0100);
    mem[1]  = ri(6'd8, 2, 0, 16'h0104);
    mem[4]  = rr(6'd1, 3, 1, 2);
    mem[5]  = rr(6'd2, 4, 2, 1);
    mem[8]  = ri(6'd9, 3, 0, 16'h0108);
    mem[9]  = ri(6'd9, 4, 0, 16'h010C);
    mem[10] = rr(6'd3, 5, 1, 2);
    mem[11] = rr(6'd4, 6, 1, 2);
    run("R8 R4", 15, 23);
    reg_is("R3", 1, 32'd5);
    reg_is("R3", 2, 32'd7);
    reg_is("R2", 3, 32'd12);
    reg_is("R2", 4, 32'd2);
    reg_is("R2", 5, 32'd5);
    reg_is("R2", 6, 32'd7);
    chk("R3", "stored sum", mem[66], 32'd12);
    chk("R3", "stored difference", mem[67], 32'd2);
  endtask

  task automatic t_dep_program();
    clear_mem();
    mem[0] = ri(6'd8, 1, 0, 16'h0100);
    mem[4] = rr(6'd1, 2, 1, 1);
    mem[5] = rr(6'd1, 3, 2, 1);
    mem[7] = rr(6'd2, 4, 3, 2);
    mem[8] = rr(6'd1, 0, 1, 1);
    mem[9] = rr(6'd4, 5, 0, 1);
    run("R5 R7 R8", 13, 21);
    reg_is("R5", 2, 32'd10);
    reg_is("R5", 3, 32'd15);
    reg_is("R6", 4, 32'd5);
    reg_is("R7", 0, 32'd0);
    reg_is("R7", 5, 32'd5);
  endtask

  task automatic t_load_use();
    clear_mem();
    mem[0] = ri(6'd8, 1, 0, 16'h0100);
    mem[1] = rr(6'd1, 2, 1, 1);
    run("R4 R5 R8", 5, 11);
    reg_is("R3", 1, 32'd5);
    reg_is("R5", 2, 32'd10);
    chk("R9", "data area untouched", mem[66], 32'd0);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_mem_program();
    t_dep_program();
    t_load_use();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule